// File: doc/BRIEF.md
# Dual-Mode 16-bit Counter/Timer

This block is a 16-bit down-counter with a byte-written reload register. A 3-bit mode field picks both the behaviour and the clock source. With the top mode bit clear it is an event counter. It counts down from the loaded value, flags the first underflow and keeps counting through the wrap until it is stopped. With the top mode bit set it is a free-running square-wave timer. It reloads itself on every underflow, flips its pin output each time and raises the ready flag on every second underflow, once per full output period.

All clock sources arrive as single-cycle enable pulses in the `clk` domain: a crystal tick, an external pin tick and two channel transmit ticks. Start and stop are single-cycle command strobes. Software writes the reload value and reads the live count one byte at a time through a single byte lane, using the same byte-select signal for both.

Top module: `ctmr_unit`

## Requirements
- R1: Mode values 0, 1, 2 and 3 are counter mode, with sources `ext_tick`, `txa_tick`, `txb_tick` and `xtal_tick`/16 respectively.
- R2: Mode values 4, 5, 6 and 7 are timer mode, with sources `ext_tick`, `ext_tick`/16, `xtal_tick` and `xtal_tick`/16 respectively. Pulses on any source that the mode does not select have no effect on the count.
- R3: A divided-by-16 source produces one count step for every 16 raw pulses. Its prescaler phase is cleared by `start_stb`.
- R4: `start_stb` loads the reload value into the counter, clears `ready` and `tog_out`, and starts counting. In timer mode a reload value of 0 loads 1.
- R5: In counter mode, a count step at 0000h wraps the count to FFFFh and sets `ready`. Counting continues afterwards, and `tog_out` never changes in this mode.
- R6: In timer mode, a count step at 0000h reloads the counter and inverts `tog_out`, so each half period is the reload value plus one steps.
- R7: In timer mode, `ready` is set only on the second, fourth, sixth and later even-numbered underflows after a start.
- R8: `stop_stb` clears `ready`. In counter mode it also halts counting from the cycle in which it arrives.
- R9: In timer mode, `stop_stb` does not halt the timer. Later underflows still reload, toggle and set `ready`.
- R10: When `wr_en` is high, `wr_data` goes to the upper reload byte if `wr_sel`=0 and to the lower reload byte if `wr_sel`=1. `rd_data` shows the upper count byte if `rd_sel` was 0 at the previous clock edge, and the lower count byte if it was 1.
- R11: After reset the count is 0000h, `ready` and `tog_out` are 0, and no source pulse changes the count before the first `start_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Mode and source select |
| xtal_tick | input | 1 | Crystal enable pulse |
| ext_tick | input | 1 | External pin enable pulse |
| txa_tick | input | 1 | Channel A transmit clock pulse |
| txb_tick | input | 1 | Channel B transmit clock pulse |
| wr_en | input | 1 | Reload byte write enable |
| wr_sel | input | 1 | Write byte select (0 upper, 1 lower) |
| wr_data | input | 8 | Reload byte data |
| rd_sel | input | 1 | Read byte select (0 upper, 1 lower) |
| rd_data | output | 8 | Registered count byte |
| start_stb | input | 1 | Start command strobe |
| stop_stb | input | 1 | Stop command strobe |
| ready | output | 1 | Counter-ready flag |
| tog_out | output | 1 | Square-wave output for a pin |

## Verification
Some internal faults show up only at the next underflow. A wrong underflow parity bit appears as `ready` rising on an odd underflow, which is one half period late or early. A bad prescaler phase shifts every count step of a divided source by up to 15 raw pulses, and a byte read one cycle after the next step shows the shift. A stuck run flag shows as a count that moves after a counter-mode stop, or that freezes in timer mode. The bench reads both count bytes right after each run of pulses, so such a fault appears within one read.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 4;

  typedef enum logic [2:0] {
    M_CNT_EXT   = 3'd0,
    M_CNT_TXA   = 3'd1,
    M_CNT_TXB   = 3'd2,
    M_CNT_XT16  = 3'd3,
    M_TMR_EXT   = 3'd4,
    M_TMR_EXT16 = 3'd5,
    M_TMR_XT    = 3'd6,
    M_TMR_XT16  = 3'd7
  } ctmr_mode_e;
endpackage

// File: rtl/ctmr_div16.sv
module ctmr_div16 #(
  parameter int PRE_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic in_tick,
  output logic out_tick
);
  logic [PRE_W-1:0] ph_q;

  assign out_tick = in_tick && (ph_q == '1);

  always_ff @(posedge clk) begin
    if (rst || clr) ph_q <= '0;
    else if (in_tick) ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/ctmr_srcsel.sv
module ctmr_srcsel
  import ctmr_pkg::*;
(
  input  logic [2:0] mode_sel,
  input  logic       xtal_tick,
  input  logic       xtal_div,
  input  logic       ext_tick,
  input  logic       ext_div,
  input  logic       txa_tick,
  input  logic       txb_tick,
  output logic       src_tick
);
  always_comb begin
    unique case (ctmr_mode_e'(mode_sel))
      M_CNT_EXT:   src_tick = ext_tick;
      M_CNT_TXA:   src_tick = txa_tick;
      M_CNT_TXB:   src_tick = txb_tick;
      M_CNT_XT16:  src_tick = xtal_div;
      M_TMR_EXT:   src_tick = ext_tick;
      M_TMR_EXT16: src_tick = ext_div;
      M_TMR_XT:    src_tick = xtal_tick;
      default:     src_tick = xtal_div;
    endcase
  end
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_timer,
  input  logic              src_tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              start_stb,
  input  logic              stop_stb,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ready,
  output logic              tog_out
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] reload_q;
  logic             run_q;
  logic             half_q;
  logic [CNT_W-1:0] load_val;
  logic             at_zero;
  logic             halt;
  logic             step;
  logic             uflow;

  assign load_val = (is_timer && reload_q == '0) ? ONE : reload_q;
  assign at_zero  = (cnt_q == '0);
  assign halt     = stop_stb && !is_timer;
  assign step     = run_q && src_tick && !halt && !start_stb;
  assign uflow    = step && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) reload_q[HALF-1:0]     <= wr_data[HALF-1:0];
      else        reload_q[CNT_W-1:HALF] <= wr_data[HALF-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      half_q  <= 1'b0;
      tog_out <= 1'b0;
    end else if (start_stb) begin
      cnt_q   <= load_val;
      run_q   <= 1'b1;
      half_q  <= 1'b0;
      tog_out <= 1'b0;
    end else begin
      if (halt) run_q <= 1'b0;
      if (step) begin
        if (at_zero && is_timer) begin
          cnt_q   <= load_val;
          tog_out <= ~tog_out;
          half_q  <= ~half_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_stb || stop_stb) ready <= 1'b0;
    else if (uflow && (!is_timer || half_q)) ready <= 1'b1;
  end

  // R4: start takes the reload value
  assert_start_load_R4: assert property (@(posedge clk) disable iff (rst)
    start_stb && !is_timer |=> cnt_q == $past(reload_q));
  assert_start_zero_R4: assert property (@(posedge clk) disable iff (rst)
    start_stb && is_timer && reload_q == '0 |=> cnt_q == ONE);
  // R5: counter mode never moves the pin output
  assert_cnt_no_tog_R5: assert property (@(posedge clk) disable iff (rst)
    !is_timer && !start_stb |=> $stable(tog_out));
  // R6: timer underflow flips the output
  assert_tmr_tog_R6: assert property (@(posedge clk) disable iff (rst)
    is_timer && uflow |=> tog_out != $past(tog_out));
  // R7: in timer mode ready rises together with the falling output edge
  assert_tmr_ready_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) && $past(is_timer) |-> $fell(tog_out));
  // R8: stop clears ready and freezes a counter
  assert_stop_clr_R8: assert property (@(posedge clk) disable iff (rst)
    stop_stb |=> !ready);
  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
    stop_stb && !is_timer && !start_stb |=> $stable(cnt_q));
endmodule

// File: rtl/ctmr_unit.sv
module ctmr_unit
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_sel,
  input  logic              xtal_tick,
  input  logic              ext_tick,
  input  logic              txa_tick,
  input  logic              txb_tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              start_stb,
  input  logic              stop_stb,
  output logic              ready,
  output logic              tog_out
);
  localparam int NPRE = 2;
  localparam int HALF = CNT_W / 2;

  logic [NPRE-1:0]  raw_tick;
  logic [NPRE-1:0]  div_tick;
  logic             src_tick;
  logic [CNT_W-1:0] cnt;

  assign raw_tick = {ext_tick, xtal_tick};

  for (genvar g = 0; g < NPRE; g++) begin : g_pre
    ctmr_div16 #(.PRE_W(PRE_W)) u_div (
      .clk      (clk),
      .rst      (rst),
      .clr      (start_stb),
      .in_tick  (raw_tick[g]),
      .out_tick (div_tick[g])
    );
  end

  ctmr_srcsel u_sel (
    .mode_sel  (mode_sel),
    .xtal_tick (xtal_tick),
    .xtal_div  (div_tick[0]),
    .ext_tick  (ext_tick),
    .ext_div   (div_tick[1]),
    .txa_tick  (txa_tick),
    .txb_tick  (txb_tick),
    .src_tick  (src_tick)
  );

  ctmr_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .is_timer  (mode_sel[2]),
    .src_tick  (src_tick),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .start_stb (start_stb),
    .stop_stb  (stop_stb),
    .cnt_q     (cnt),
    .ready     (ready),
    .tog_out   (tog_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? cnt[HALF-1:0] : cnt[CNT_W-1:HALF];
  end

  // R10: read lane follows the selected count byte one cycle later
  assert_rd_lane_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_data == ($past(rd_sel) ? $past(cnt[HALF-1:0]) : $past(cnt[CNT_W-1:HALF])));
endmodule

// File: tb/ctmr_unit_bench.sv
module ctmr_unit_bench;
  localparam int NV = 9;
  localparam logic [2:0]  V_MODE [NV] = '{3'd3, 3'd0, 3'd1, 3'd2, 3'd6, 3'd6, 3'd4, 3'd5, 3'd7};
  localparam logic [15:0] V_RLD  [NV] = '{16'h0005, 16'h0005, 16'h0100, 16'h0000, 16'h0002,
                                          16'h0002, 16'h0000, 16'h0001, 16'h0003};
  localparam int          V_N    [NV] = '{3, 6, 2, 2, 3, 6, 2, 2, 8};
  localparam logic [15:0] V_CNT  [NV] = '{16'h0002, 16'hFFFF, 16'h00FE, 16'hFFFE, 16'h0002,
                                          16'h0002, 16'h0001, 16'h0001, 16'h0003};
  localparam logic        V_RDY  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic        V_TOG  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode_sel = '0;
  logic xtal_tick = 0, ext_tick = 0, txa_tick = 0, txb_tick = 0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0, start_stb = 0, stop_stb = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic ready, tog_out;

  int n_chk = 0;
  int n_bad = 0;
  string v_req [NV];

  always #10 clk = ~clk;

  ctmr_unit u_ctmr_unit (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .xtal_tick(xtal_tick), .ext_tick(ext_tick), .txa_tick(txa_tick), .txb_tick(txb_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .start_stb(start_stb), .stop_stb(stop_stb),
    .ready(ready), .tog_out(tog_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // raw source: 0 ext, 1 txa, 2 txb, 3 xtal
  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ext_tick  = (src == 0);
      txa_tick  = (src == 1);
      txb_tick  = (src == 2);
      xtal_tick = (src == 3);
      @(negedge clk);
      {ext_tick, txa_tick, txb_tick, xtal_tick} = '0;
    end
  endtask

  task automatic steps(input logic [2:0] m, input int n);
    case (m)
      3'd0, 3'd4: pulse(0, n);
      3'd1:       pulse(1, n);
      3'd2:       pulse(2, n);
      3'd6:       pulse(3, n);
      3'd5:       pulse(0, 16 * n);
      default:    pulse(3, 16 * n);
    endcase
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = v[15:8];
    @(negedge clk); wr_sel = 1; wr_data = v[7:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic strobe(input bit is_start);
    @(negedge clk);
    if (is_start) start_stb = 1; else stop_stb = 1;
    @(negedge clk);
    start_stb = 0; stop_stb = 0;
  endtask

  task automatic read_cnt(output logic [15:0] v);
    @(negedge clk); rd_sel = 0;
    @(negedge clk); v[15:8] = rd_data; rd_sel = 1;
    @(negedge clk); v[7:0] = rd_data;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] c;
    v_req = '{"R1 R3", "R1 R5", "R1", "R5", "R2 R6", "R7", "R4", "R3 R6", "R7"};
    repeat (3) @(negedge clk);
    rst = 0;

    // R11: reset state, idle before start
    read_cnt(c);
    check("R11 count", c, 16'h0000);
    check("R11 ready", ready, 0);
    check("R11 tog", tog_out, 0);
    mode_sel = 3'd6;
    pulse(3, 5);
    read_cnt(c);
    check("R11 no count before start", c, 16'h0000);

    // vector table
    for (int k = 0; k < NV; k++) begin
      mode_sel = V_MODE[k];
      load(V_RLD[k]);
      strobe(1);
      steps(V_MODE[k], V_N[k]);
      read_cnt(c);
      check({v_req[k], " count"}, c, V_CNT[k]);
      check({v_req[k], " ready"}, ready, V_RDY[k]);
      check({v_req[k], " tog"}, tog_out, V_TOG[k]);
    end

    // R10: byte write and byte readback
    mode_sel = 3'd0;
    load(16'hA55A);
    strobe(1);
    read_cnt(c);
    check("R10 bytes", c, 16'hA55A);

    // R2: unselected sources ignored in timer mode
    mode_sel = 3'd6;
    load(16'h0004);
    strobe(1);
    pulse(0, 3); pulse(1, 3); pulse(2, 3);
    read_cnt(c);
    check("R2 unselected ignored", c, 16'h0004);

    // R8: counter stop
    mode_sel = 3'd0;
    load(16'h0000);
    strobe(1);
    pulse(0, 1);
    check("R8 ready before stop", ready, 1);
    strobe(0);
    check("R8 ready cleared", ready, 0);
    pulse(0, 2);
    read_cnt(c);
    check("R8 halted", c, 16'hFFFF);

    // R9: timer keeps running after stop
    mode_sel = 3'd6;
    load(16'h0001);
    strobe(1);
    pulse(3, 4);
    check("R9 ready set", ready, 1);
    strobe(0);
    check("R9 ready cleared", ready, 0);
    pulse(3, 2);
    check("R9 still toggling", tog_out, 1);
    check("R9 odd underflow no ready", ready, 0);
    pulse(3, 2);
    check("R9 ready again", ready, 1);
    read_cnt(c);
    check("R9 reloaded", c, 16'h0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule